// File: doc/BRIEF.md
# SIMD Floating-Point Compare-With-Zero Unit

This block tests every floating-point lane of a packed operand of up to 128 bits against zero and returns a lane mask. A lane that is greater than or equal to zero becomes all ones. Any other lane becomes all zeros. Lanes may be half, single or double precision. The operand shape is a 64-bit vector, a 128-bit vector, or a scalar that holds one lane in the low bits.

The compare is signalling and ordered. Any NaN lane is false and raises invalid-operation. Negative zero counts as equal to zero. A control input sends an invalid result either to a sticky status flag or to a synchronous trap request. A trapped result is marked as not to be written back. One shape is illegal: a vector of doubles that is only 64 bits wide. For that shape the unit flags an undefined encoding and produces nothing.

Each result is registered one cycle after the operation is accepted.

Top module: `fzc_unit`

## Requirements
- R1: A lane is set to all ones when its value is +0, -0, a positive subnormal, a positive normal or +infinity. It is cleared to all zeros when its value is negative and non-zero, including negative subnormals and -infinity.
- R2: A NaN lane, quiet or signalling, gives an all-zeros lane and sets `op_invalid`.
- R3: Lane width is chosen as follows: `half_mode`=1 gives 16-bit lanes whatever `size_bit` is; `half_mode`=0 with `size_bit`=0 gives 32-bit lanes; `half_mode`=0 with `size_bit`=1 gives 64-bit lanes.
- R4: `vec_mode`=1 processes 64 bits of data when `q_bit`=0 and 128 bits when `q_bit`=1, that is, data width divided by lane width lanes. `vec_mode`=0 processes exactly one lane in the low bits.
- R5: Every mask bit above the active data width is 0.
- R6: `op_invalid` is the OR over the active lanes only. A NaN pattern in inactive bits never sets it.
- R7: The combination `vec_mode`=1, `half_mode`=0, `size_bit`=1, `q_bit`=0 sets `undef`. It also forces `mask` to all zeros, `op_invalid`=0, `trap_req`=0 and `wb_en`=0, and leaves `sticky_invalid` unchanged.
- R8: When `trap_en`=1 and invalid is raised, `trap_req`=1 and `wb_en`=0, and `sticky_invalid` is not changed by that operation.
- R9: When `trap_en`=0 and invalid is raised, `sticky_invalid` becomes 1 and stays 1 until reset, and `wb_en`=1.
- R10: The results of an operation accepted on a rising edge with `in_valid`=1 appear after that edge, with `out_valid`=1. `out_valid`, `wb_en` and `trap_req` are 0 in cycles without an operation. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| half_mode | input | 1 | 1: 16-bit lanes |
| size_bit | input | 1 | With half_mode=0: 0 single, 1 double |
| vec_mode | input | 1 | 1: vector shape, 0: scalar |
| q_bit | input | 1 | Vector width: 0 is 64 bits, 1 is 128 bits |
| trap_en | input | 1 | 1: invalid raises a trap instead of the flag |
| operand | input | 128 | Packed source lanes, lane 0 in the low bits |
| out_valid | output | 1 | Registered result present |
| mask | output | 128 | Lane masks, zero above the active width |
| op_invalid | output | 1 | Invalid raised by this operation |
| sticky_invalid | output | 1 | Cumulative invalid flag |
| trap_req | output | 1 | Synchronous trap request |
| wb_en | output | 1 | Result may be written back |
| undef | output | 1 | Illegal shape encoding |

## Verification
The hardest case to reach from the ports is a NaN that sits only in inactive bits while the active lanes are clean. Here `op_invalid` and the flag must stay low even though the raw operand holds a NaN pattern. Directed cases place NaNs in the upper half of a 64-bit vector and above a scalar lane. The random operands are also built from 16-bit chunks that are often all-ones exponents or zeros, so NaNs, infinities and signed zeros show up in every lane format and every shape. The random trap enable and the illegal shape are mixed in, so the sticky flag's response to trapped and undefined operations is exercised.

// File: rtl/fzc_pkg.sv
package fzc_pkg;
  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2
  } fzc_fmt_e;
endpackage

// File: rtl/fzc_lane_cmp.sv
module fzc_lane_cmp #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int LANE_W = 1 + EXP_W + MAN_W
) (
  input  logic [LANE_W-1:0] val,
  output logic              ge_zero,
  output logic              is_nan
);
  logic             sign;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;

  always_comb begin
    sign    = val[LANE_W-1];
    expo    = val[LANE_W-2 -: EXP_W];
    man     = val[MAN_W-1:0];
    is_nan  = (&expo) && (|man);
    ge_zero = !is_nan && (!sign || ((expo == '0) && (man == '0)));
  end
endmodule

// File: rtl/fzc_shape_decode.sv
module fzc_shape_decode
  import fzc_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int CHUNKS = DATA_W / 16
) (
  input  logic              half_mode,
  input  logic              size_bit,
  input  logic              vec_mode,
  input  logic              q_bit,
  output fzc_fmt_e          fmt,
  output logic              undef,
  output logic [CHUNKS-1:0] chunk_en
);
  int n_chunks;

  always_comb begin
    if (half_mode)     fmt = FMT_HALF;
    else if (size_bit) fmt = FMT_DOUBLE;
    else               fmt = FMT_SINGLE;
    undef = vec_mode && !half_mode && size_bit && !q_bit;
    if (vec_mode) n_chunks = q_bit ? CHUNKS : CHUNKS / 2;
    else          n_chunks = 1 << fmt;
    for (int c = 0; c < CHUNKS; c++)
      chunk_en[c] = !undef && (c < n_chunks);
  end
endmodule

// File: rtl/fzc_status.sv
module fzc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic undef_now,
  input  logic inv_now,
  input  logic trap_en,
  output logic out_valid,
  output logic sticky_invalid,
  output logic trap_req,
  output logic wb_en
);
  logic valid_d, sticky_d, trap_d, wb_d;

  always_comb begin
    valid_d  = in_valid;
    trap_d   = in_valid && !undef_now && inv_now && trap_en;
    wb_d     = in_valid && !undef_now && !trap_d;
    sticky_d = sticky_invalid || (in_valid && !undef_now && inv_now && !trap_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      sticky_invalid <= 1'b0;
      trap_req       <= 1'b0;
      wb_en          <= 1'b0;
    end else begin
      out_valid      <= valid_d;
      sticky_invalid <= sticky_d;
      trap_req       <= trap_d;
      wb_en          <= wb_d;
    end
  end

  AST_TRAP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !wb_en); // R8
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_invalid |=> sticky_invalid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wb_en && !trap_req)); // R10
endmodule

// File: rtl/fzc_unit.sv
module fzc_unit
  import fzc_pkg::*;
#(
  parameter int DATA_W = 128,
  localparam int CHUNKS = DATA_W / 16,
  localparam int N_H = DATA_W / 16,
  localparam int N_S = DATA_W / 32,
  localparam int N_D = DATA_W / 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              half_mode,
  input  logic              size_bit,
  input  logic              vec_mode,
  input  logic              q_bit,
  input  logic              trap_en,
  input  logic [DATA_W-1:0] operand,
  output logic              out_valid,
  output logic [DATA_W-1:0] mask,
  output logic              op_invalid,
  output logic              sticky_invalid,
  output logic              trap_req,
  output logic              wb_en,
  output logic              undef
);
  fzc_fmt_e          fmt;
  logic              undef_now;
  logic [CHUNKS-1:0] chunk_en;
  logic [N_H-1:0]    ge_h, nan_h;
  logic [N_S-1:0]    ge_s, nan_s;
  logic [N_D-1:0]    ge_d, nan_d;
  logic [DATA_W-1:0] mask_h, mask_s, mask_d, mask_d_nx;
  logic              inv_h, inv_s, inv_d, inv_nx;
  logic [CHUNKS-1:0] width_q;

  fzc_shape_decode #(.DATA_W(DATA_W)) u_dec (
    .half_mode(half_mode), .size_bit(size_bit), .vec_mode(vec_mode),
    .q_bit(q_bit), .fmt(fmt), .undef(undef_now), .chunk_en(chunk_en)
  );

  for (genvar g = 0; g < N_H; g++) begin : g_half
    fzc_lane_cmp #(.EXP_W(5), .MAN_W(10)) u_l (
      .val(operand[16*g +: 16]), .ge_zero(ge_h[g]), .is_nan(nan_h[g]));
  end
  for (genvar g = 0; g < N_S; g++) begin : g_single
    fzc_lane_cmp #(.EXP_W(8), .MAN_W(23)) u_l (
      .val(operand[32*g +: 32]), .ge_zero(ge_s[g]), .is_nan(nan_s[g]));
  end
  for (genvar g = 0; g < N_D; g++) begin : g_double
    fzc_lane_cmp #(.EXP_W(11), .MAN_W(52)) u_l (
      .val(operand[64*g +: 64]), .ge_zero(ge_d[g]), .is_nan(nan_d[g]));
  end

  always_comb begin
    inv_h = 1'b0;
    inv_s = 1'b0;
    inv_d = 1'b0;
    for (int i = 0; i < N_H; i++) begin
      mask_h[16*i +: 16] = {16{ge_h[i] & chunk_en[i]}};
      inv_h = inv_h | (nan_h[i] & chunk_en[i]);
    end
    for (int i = 0; i < N_S; i++) begin
      mask_s[32*i +: 32] = {32{ge_s[i] & chunk_en[2*i]}};
      inv_s = inv_s | (nan_s[i] & chunk_en[2*i]);
    end
    for (int i = 0; i < N_D; i++) begin
      mask_d[64*i +: 64] = {64{ge_d[i] & chunk_en[4*i]}};
      inv_d = inv_d | (nan_d[i] & chunk_en[4*i]);
    end
    case (fmt)
      FMT_HALF:   begin mask_d_nx = mask_h; inv_nx = inv_h; end
      FMT_SINGLE: begin mask_d_nx = mask_s; inv_nx = inv_s; end
      default:    begin mask_d_nx = mask_d; inv_nx = inv_d; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask       <= '0;
      op_invalid <= 1'b0;
      undef      <= 1'b0;
      width_q    <= '0;
    end else if (in_valid) begin
      mask       <= mask_d_nx;
      op_invalid <= inv_nx;
      undef      <= undef_now;
      width_q    <= chunk_en;
    end
  end

  fzc_status u_stat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .undef_now(undef_now),
    .inv_now(inv_nx), .trap_en(trap_en), .out_valid(out_valid),
    .sticky_invalid(sticky_invalid), .trap_req(trap_req), .wb_en(wb_en)
  );

  logic [DATA_W-1:0] width_bits;
  always_comb
    for (int c = 0; c < CHUNKS; c++) width_bits[16*c +: 16] = {16{width_q[c]}};

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~width_bits) == '0); // R5
  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && undef) |-> (mask == '0 && !op_invalid && !wb_en && !trap_req)); // R7
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
endmodule

// File: tb/sim_fzc_unit.sv
module sim_fzc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, half_mode = 1'b0, size_bit = 1'b0, vec_mode = 1'b0;
  logic q_bit = 1'b0, trap_en = 1'b0;
  logic [127:0] operand = '0;
  logic out_valid, op_invalid, sticky_invalid, trap_req, wb_en, undef;
  logic [127:0] mask;
  int checks = 0, fails = 0;
  logic exp_sticky = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  fzc_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .half_mode(half_mode),
    .size_bit(size_bit), .vec_mode(vec_mode), .q_bit(q_bit), .trap_en(trap_en),
    .operand(operand), .out_valid(out_valid), .mask(mask), .op_invalid(op_invalid),
    .sticky_invalid(sticky_invalid), .trap_req(trap_req), .wb_en(wb_en), .undef(undef));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // classify one lane of width lw held in the low bits of v
  function automatic void ref_lane(input logic [63:0] v, input int lw,
                                   output logic ge, output logic nan);
    logic [63:0] mag, inf;
    logic s;
    s   = v[lw-1];
    mag = v & ((64'd1 << (lw-1)) - 64'd1);
    if (lw == 16)      inf = 64'h7C00;
    else if (lw == 32) inf = 64'h7F80_0000;
    else               inf = 64'h7FF0_0000_0000_0000;
    nan = mag > inf;
    ge  = !nan && (!s || mag == 0);
  endfunction

  task automatic run(input string tag, input logic h, input logic sz, input logic vm,
                     input logic q, input logic te, input logic [127:0] op);
    int lw, dw;
    logic ge, nan, inv, ud;
    logic [127:0] em;
    logic [63:0] lv;
    half_mode = h; size_bit = sz; vec_mode = vm; q_bit = q; trap_en = te;
    operand = op; in_valid = 1'b1;
    lw = h ? 16 : (sz ? 64 : 32);
    dw = vm ? (q ? 128 : 64) : lw;
    ud = vm && !h && sz && !q;
    em = '0; inv = 1'b0;
    if (!ud)
      for (int l = 0; l < dw / lw; l++) begin
        lv = 64'(op >> (l * lw));
        if (lw < 64) lv = lv & ((64'd1 << lw) - 64'd1);
        ref_lane(lv, lw, ge, nan);
        inv = inv | nan;
        if (ge) em = em | (((lw == 64) ? {64'd0, {64{1'b1}}} :
                            ((128'd1 << lw) - 128'd1)) << (l * lw));
      end
    if (!ud && inv && !te) exp_sticky = 1'b1;
    @(negedge clk);
    chk({tag, " mask R1 R3 R4 R5"}, mask, em);
    chk({tag, " op_invalid R2 R6"}, 128'(op_invalid), 128'(inv));
    chk({tag, " undef R7"}, 128'(undef), 128'(ud));
    chk({tag, " trap_req R8"}, 128'(trap_req), 128'(!ud && inv && te));
    chk({tag, " wb_en R8 R9"}, 128'(wb_en), 128'(!ud && !(inv && te)));
    chk({tag, " sticky R9"}, 128'(sticky_invalid), 128'(exp_sticky));
    chk({tag, " out_valid R10"}, 128'(out_valid), 128'd1);
  endtask

  function automatic logic [15:0] pick_chunk();
    case ($urandom_range(0, 7))
      0: return 16'h0000;
      1: return 16'h8000;
      2: return 16'h7FFF;
      3: return 16'hFFFF;
      4: return 16'h7C00;
      5: return 16'h7FF0;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] op;
    void'($urandom(32'd7));
    repeat (2) @(negedge clk);
    chk("reset mask R10", mask, '0);
    chk("reset flags R10", {123'd0, out_valid, op_invalid, sticky_invalid, trap_req, wb_en},
        '0);
    chk("reset undef R10", 128'(undef), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 half specials: +0,-0,+sub,-sub,+inf,-inf,+1,-1
    run("dir half signs", 1, 0, 1, 1, 0, 128'h7C00_FC00_0001_8001_8000_0000_3C00_BC00);
    // R1 single: -0, +inf ; upper half dirty, Q=0
    run("dir single q0", 0, 0, 1, 0, 0, {64'hFFFF_FFFF_7FFF_FFFF, 64'h8000_0000_7F80_0000});
    // R1 double -0 and negative subnormal
    run("dir double", 0, 1, 1, 1, 0, {64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000});
    // R6 NaN only above scalar lane
    run("dir scalar nan above", 1, 0, 0, 0, 0, {112'h7FFF_7E00_7E00_7E00_7E00_7E00_7E00, 16'h0001});
    // R2 R8 trapped NaN in double lane 1
    run("dir trap nan", 0, 1, 1, 1, 1, {64'h7FF0_0000_0000_0001, 64'h0000_0000_0000_0001});
    // R7 illegal shape
    run("dir undef", 0, 1, 1, 0, 0, {128{1'b1}});
    // R2 R9 flag path, half quiet NaN
    run("dir flag nan", 1, 1, 1, 0, 0, 128'h0000_0000_0000_0000_7E00_0000_0000_0000);
    run("dir after flag", 0, 0, 0, 1, 0, 128'h1);
    // R10 idle cycle
    in_valid = 1'b0;
    @(negedge clk);
    chk("idle out_valid R10", 128'(out_valid), 128'd0);
    chk("idle wb_trap R10", {126'd0, wb_en, trap_req}, '0);
    for (int n = 0; n < 400; n++) begin
      for (int c = 0; c < 8; c++) op[16*c +: 16] = pick_chunk();
      if (n == 200) begin
        rst_n = 1'b0; exp_sticky = 1'b0; in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("rerun sticky cleared R9", 128'(sticky_invalid), 128'd0);
      end
      run("rand", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          ($urandom_range(0, 3) == 0), op);
    end
    in_valid = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule